// File: doc/BRIEF.md
# Pipelined Coefficient Quantizer with Rounding

This block scales transform coefficients for a lossy image encoder. It accepts one signed coefficient and one unsigned divisor on every enabled clock. The coefficient is divided by the divisor with the quotient truncated toward zero. The quotient is then halved, and the halved value is rounded up when the dropped bit is one. The result is one bit narrower than the coefficient. The divider is unrolled into one register stage per quotient bit, so a new pair can enter on every clock. Each result leaves after a fixed latency.

A one-cycle start pulse marks the first pair of a stream. The valid flag rises when that pair's result reaches the output and then stays high. A clock enable freezes the whole pipeline. An optional 6-bit position counter reports where the most recently accepted pair sits within a 64-entry block.

Top module: `qz_quantizer`

## Requirements
- R1: For an accepted pair, let t be the coefficient divided by the divisor, truncated toward zero, and let w be t as a 12-bit two's-complement word. The result is w[11:1] plus w[0], kept modulo 2^11. For example, t = -3 gives -1, and t = 2047 wraps to -1024.
- R2: R1 holds across the whole coefficient range from -2048 to 2047 and for every divisor from 1 to 255, including the extreme coefficients and the divisors 1, 2 and 255.
- R3: A pair sampled at an enabled clock edge produces its result after 13 enabled edges, counting that edge. Once the pipeline is full, one result comes out per enabled cycle.
- R4: After reset, res_vld stays 0 until a start pulse is sampled with ena high. It rises together with the result of the pair sampled with that start pulse. It then stays 1 until reset.
- R5: While ena is low, res, res_vld and blk_pos hold their values, and the pair and start present on the inputs are not taken.
- R6: blk_pos becomes 0 at the enabled edge that samples start. It rises by one at each later enabled edge and wraps from 63 to 0. It stays 0 before the first start.
- R7: A synchronous active-high reset clears res, res_vld and blk_pos to 0.
- R8: A start pulse during a running stream restarts blk_pos at 0. It leaves res_vld high and the result stream unbroken.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ena | input | 1 | Clock enable for every stage |
| start | input | 1 | One-cycle pulse marking the first pair of a stream |
| coef | input | 12 | Signed coefficient |
| qval | input | 8 | Unsigned divisor, 1 to 255 |
| res | output | 11 | Signed rounded quotient |
| res_vld | output | 1 | Result valid, sticky after the first result |
| blk_pos | output | 6 | Position of the latest accepted pair within a block |

## Verification
Each result is due exactly 13 enabled edges after its pair was sampled, and blk_pos is due one edge after the sampling edge. Disabled cycles add no edges to either count. The bench counts enabled edges since the first start and keeps every accepted pair in a ring indexed by that count. At each falling edge it compares res with the pair recorded 13 enabled edges earlier. It also compares blk_pos with its own position model, which is updated from the inputs held during the preceding rising edge. In cycles where ena was low, the bench additionally requires that the outputs did not change.

// File: rtl/qz_pkg.sv
package qz_pkg;
  // default widths of the quantizer datapath
  localparam int QZ_CW = 12;  // coefficient width
  localparam int QZ_DW = 8;   // divisor width
  localparam int QZ_PW = 6;   // block position counter width
endpackage

// File: rtl/qz_div_step.sv
// One restoring-division step: brings in the next dividend bit and produces one quotient bit.
module qz_div_step #(
  parameter int CW = 12,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          ena,
  input  logic [CW-1:0] in_nq,
  input  logic [DW-1:0] in_rem,
  input  logic [DW-1:0] in_dvs,
  input  logic          in_neg,
  output logic [CW-1:0] out_nq,
  output logic [DW-1:0] out_rem,
  output logic [DW-1:0] out_dvs,
  output logic          out_neg
);
  logic [DW:0] trial;
  logic [DW:0] diff;
  logic        fits;

  always_comb begin
    trial = {in_rem, in_nq[CW-1]};
    diff  = trial - {1'b0, in_dvs};
    fits  = (trial >= {1'b0, in_dvs});
  end

  // Dividend bits shift out at the top and quotient bits shift in at the bottom of one register.
  always_ff @(posedge clk) begin
    if (ena) begin
      out_nq  <= {in_nq[CW-2:0], fits};
      out_rem <= fits ? diff[DW-1:0] : trial[DW-1:0];
      out_dvs <= in_dvs;
      out_neg <= in_neg;
    end
  end
endmodule

// File: rtl/qz_divider.sv
// Sign-magnitude divider unrolled into CW register stages.
module qz_divider #(
  parameter int CW = 12,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          ena,
  input  logic [CW-1:0] coef,
  input  logic [DW-1:0] qval,
  output logic [CW-1:0] quo_mag,
  output logic          quo_neg
);
  logic [CW-1:0] nq_c  [0:CW];
  logic [DW-1:0] rem_c [0:CW];
  logic [DW-1:0] dvs_c [0:CW];
  logic          neg_c [0:CW];

  // Magnitude of the coefficient; the most negative value maps to 2^(CW-1) as unsigned.
  always_comb begin
    neg_c[0] = coef[CW-1];
    nq_c[0]  = coef[CW-1] ? (~coef + 1'b1) : coef;
    rem_c[0] = '0;
    dvs_c[0] = qval;
  end

  for (genvar k = 0; k < CW; k++) begin : g_step
    qz_div_step #(.CW(CW), .DW(DW)) u_step (
      .clk     (clk),
      .ena     (ena),
      .in_nq   (nq_c[k]),
      .in_rem  (rem_c[k]),
      .in_dvs  (dvs_c[k]),
      .in_neg  (neg_c[k]),
      .out_nq  (nq_c[k+1]),
      .out_rem (rem_c[k+1]),
      .out_dvs (dvs_c[k+1]),
      .out_neg (neg_c[k+1])
    );
  end

  assign quo_mag = nq_c[CW];
  assign quo_neg = neg_c[CW];
endmodule

// File: rtl/qz_round.sv
// Restores the sign, halves the quotient and rounds up on an odd quotient, then registers the result.
module qz_round #(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ena,
  input  logic [CW-1:0] mag,
  input  logic          neg,
  output logic [CW-2:0] res
);
  logic [CW-1:0] sq;

  always_comb sq = neg ? (~mag + 1'b1) : mag;

  always_ff @(posedge clk) begin
    if (rst) begin
      res <= '0;
    end else if (ena) begin
      res <= sq[CW-1:1] + {{(CW-2){1'b0}}, sq[0]};
    end
  end
endmodule

// File: rtl/qz_ctrl.sv
// Stream control: a valid shift register that matches the datapath depth, plus the block position counter.
module qz_ctrl #(
  parameter int LAT     = 13,
  parameter int PW      = 6,
  parameter bit HAS_POS = 1'b1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ena,
  input  logic          start,
  output logic          res_vld,
  output logic [PW-1:0] blk_pos
);
  logic           running;
  logic [LAT-1:0] vpipe;

  always_ff @(posedge clk) begin
    if (rst) begin
      running <= 1'b0;
      vpipe   <= '0;
    end else if (ena) begin
      if (start) running <= 1'b1;
      vpipe <= {vpipe[LAT-2:0], start | running};
    end
  end

  assign res_vld = vpipe[LAT-1];

  if (HAS_POS) begin : g_pos
    logic [PW-1:0] pos_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        pos_q <= '0;
      end else if (ena) begin
        if (start)        pos_q <= '0;
        else if (running) pos_q <= pos_q + 1'b1;
      end
    end
    assign blk_pos = pos_q;
  end else begin : g_nopos
    assign blk_pos = '0;
  end
endmodule

// File: rtl/qz_quantizer.sv
module qz_quantizer
  import qz_pkg::*;
#(
  parameter int CW      = QZ_CW,
  parameter int DW      = QZ_DW,
  parameter int PW      = QZ_PW,
  parameter bit HAS_POS = 1'b1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ena,
  input  logic          start,
  input  logic [CW-1:0] coef,
  input  logic [DW-1:0] qval,
  output logic [CW-2:0] res,
  output logic          res_vld,
  output logic [PW-1:0] blk_pos
);
  // CW divider stages followed by one rounding stage
  localparam int LAT = CW + 1;

  logic [CW-1:0] q_mag;
  logic          q_neg;

  qz_divider #(.CW(CW), .DW(DW)) u_div (
    .clk     (clk),
    .ena     (ena),
    .coef    (coef),
    .qval    (qval),
    .quo_mag (q_mag),
    .quo_neg (q_neg)
  );

  qz_round #(.CW(CW)) u_rnd (
    .clk (clk),
    .rst (rst),
    .ena (ena),
    .mag (q_mag),
    .neg (q_neg),
    .res (res)
  );

  qz_ctrl #(.LAT(LAT), .PW(PW), .HAS_POS(HAS_POS)) u_ctl (
    .clk     (clk),
    .rst     (rst),
    .ena     (ena),
    .start   (start),
    .res_vld (res_vld),
    .blk_pos (blk_pos)
  );
endmodule

// File: rtl/qz_quantizer_chk.sv
module qz_quantizer_chk #(
  parameter int CW = 12,
  parameter int PW = 6
) (
  input logic          clk,
  input logic          rst,
  input logic          ena,
  input logic          start,
  input logic [CW-2:0] res,
  input logic          res_vld,
  input logic [PW-1:0] blk_pos
);
  localparam int LAT = CW + 1;

  // enabled edges since the first sampled start, saturating at LAT
  int unsigned seen;
  always_ff @(posedge clk) begin
    if (rst) seen <= 0;
    else if (ena && (start || seen != 0) && seen < LAT) seen <= seen + 1;
  end

  AST_FREEZE_ON_STALL: assert property (@(posedge clk) disable iff (rst)
    !ena |=> ($stable(res) && $stable(res_vld) && $stable(blk_pos))); // R5
  AST_VLD_STICKY: assert property (@(posedge clk) disable iff (rst)
    res_vld |=> res_vld); // R4
  AST_VLD_LATENCY: assert property (@(posedge clk) disable iff (rst)
    res_vld == (seen >= LAT)); // R3
  AST_POS_CLEAR_ON_START: assert property (@(posedge clk) disable iff (rst)
    (ena && start) |=> (blk_pos == '0)); // R8
  AST_POS_STEP: assert property (@(posedge clk) disable iff (rst)
    (ena && !start && blk_pos != '0) |=> (blk_pos == PW'($past(blk_pos) + 1'b1))); // R6
  AST_POS_IDLE: assert property (@(posedge clk) disable iff (rst)
    (seen == 0) |-> (blk_pos == '0)); // R6
endmodule

bind qz_quantizer qz_quantizer_chk #(.CW(CW), .PW(PW)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .ena     (ena),
  .start   (start),
  .res     (res),
  .res_vld (res_vld),
  .blk_pos (blk_pos)
);

// File: tb/qz_quantizer_tb.sv
module qz_quantizer_tb;
  localparam int CW  = 12;
  localparam int DW  = 8;
  localparam int PW  = 6;
  localparam int LAT = CW + 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          ena = 1'b1;
  logic          start = 1'b0;
  logic [CW-1:0] coef = '0;
  logic [DW-1:0] qval = 8'd1;
  logic [CW-2:0] res;
  logic          res_vld;
  logic [PW-1:0] blk_pos;

  // 20 ns period, 50 MHz
  always #10 clk = ~clk;

  qz_quantizer u_dut (
    .clk(clk), .rst(rst), .ena(ena), .start(start),
    .coef(coef), .qval(qval), .res(res), .res_vld(res_vld), .blk_pos(blk_pos)
  );

  int        n_chk = 0;
  int        n_fail = 0;
  logic [CW-1:0] hc [0:63];
  logic [DW-1:0] hq [0:63];
  int        nen = 0;
  bit        started = 0;
  int        pos_e = 0;
  logic [CW-2:0] prev_res = '0;
  string     vtag = "R1";

  function automatic logic [CW-2:0] model(logic [CW-1:0] c, logic [DW-1:0] q);
    int ci = $signed(c);
    int qt = ci / int'(q);
    logic [CW-1:0] w = CW'(qt);
    return w[CW-1:1] + (CW-1)'(w[0]);
  endfunction

  task automatic chk(bit ok, string tag, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  // One cycle: account for the edge just passed, check the outputs, then drive the next inputs.
  task automatic cyc(bit s, bit e, logic [CW-1:0] c, logic [DW-1:0] q);
    @(negedge clk);
    if (!rst && ena) begin
      if (start || started) begin
        hc[nen % 64] = coef;
        hq[nen % 64] = qval;
        nen++;
      end
      if (start) pos_e = 0;
      else if (started) pos_e = (pos_e + 1) % 64;
      if (start) started = 1;
    end
    if (!ena) chk(res == prev_res, "R5", res, prev_res);
    if (nen >= LAT) begin
      logic [CW-2:0] ex;
      ex = model(hc[(nen - LAT) % 64], hq[(nen - LAT) % 64]);
      chk(res_vld == 1'b1, "R3", res_vld, 1);
      chk(res == ex, vtag, $signed(res), $signed(ex));
    end else begin
      chk(res_vld == 1'b0, "R4", res_vld, 0);
    end
    chk(blk_pos == PW'(pos_e), "R6", blk_pos, pos_e);
    prev_res = res;
    start = s; ena = e; coef = c; qval = q;
  endtask

  function automatic logic [DW-1:0] rq();
    return DW'(($urandom % 255) + 1);
  endfunction

  initial begin
    int cl [10] = '{-2048, -2047, -3, -1, 0, 1, 2, 3, 2047, 1000};
    int ql [6]  = '{1, 2, 3, 127, 254, 255};
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R7: state after reset
    chk(res == '0, "R7", res, 0);
    chk(res_vld == 1'b0, "R7", res_vld, 0);
    chk(blk_pos == '0, "R7", blk_pos, 0);
    rst = 1'b0;
    // R4, R6: no stream before start
    for (int i = 0; i < 20; i++) cyc(0, 1, CW'($urandom), rq());
    cyc(1, 1, CW'($urandom), rq());
    vtag = "R1";
    for (int i = 0; i < 600; i++) cyc(0, 1, CW'($urandom), rq());
    vtag = "R2";
    foreach (cl[i]) foreach (ql[j]) cyc(0, 1, CW'(cl[i]), DW'(ql[j]));
    vtag = "R5";
    for (int i = 0; i < 800; i++) begin
      bit e = ($urandom % 4) != 0;
      bit s = (!e) && (($urandom % 16) == 0);  // start while stalled is ignored
      cyc(s, e, CW'($urandom), rq());
    end
    vtag = "R8";
    for (int i = 0; i < 3; i++) begin
      cyc(1, 1, CW'($urandom), rq());
      for (int k = 0; k < 90; k++) cyc(0, ($urandom % 8) != 0, CW'($urandom), rq());
    end
    vtag = "R1";
    for (int i = 0; i < LAT + 4; i++) cyc(0, 1, CW'($urandom), rq());
    // R7: reset in the middle of a stream
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    chk(res == '0, "R7", res, 0);
    chk(res_vld == 1'b0, "R7", res_vld, 0);
    chk(blk_pos == '0, "R7", blk_pos, 0);
    summary();
    $finish;
  end

  initial begin
    #(20 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end
endmodule